// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block takes a pair of stereo samples from a converter and sends them out on a three-wire serial audio link: a serial data line, a frame clock that tells left from right, and a bit clock. The whole block runs on the master clock. As clock master it divides the master clock down to make the bit clock and the frame clock. As clock slave it samples an external bit clock and frame clock, follows their edges and sends its data in step with them.

The configuration inputs are static and already decoded. They select master or slave operation, the master-clock-to-sample-rate ratio, one of three framing formats (I2S, left-justified, right-justified) and a word length of 16, 20 or 24 bits. Samples come in MSB-aligned on 24-bit inputs. Each channel's sample is copied into a holding register when that channel's half-frame begins, so the source can update its inputs at any time.

Top module: `aso_port`

## Requirements
- R1: With `cfg_master`=1 the frame holds 64 bit periods, or 48 when `cfg_ratio` is 1 (192x) or 5 (768x). Each bit period lasts 2, 4, 4, 6, 8 or 16 clock cycles for `cfg_ratio` 0..5 (128x, 192x, 256x, 384x, 512x, 768x), and 4 cycles for codes 6 and 7. `bclk_out` is low for the first half of each bit period and high for the second half. The first bit period begins at the first clock edge after reset is released.
- R2: In master mode `lrclk_out` marks the half-frame. For `cfg_fmt`=0 (I2S) it is low for the left half and high for the right half. For the justified formats it is high for the left half. It changes only together with a falling edge of `bclk_out`.
- R3: Left-justified (`cfg_fmt`=1, and also code 3) sends the sample MSB first in bit slot 0 of its half. Serial data changes only while the bit clock is low.
- R4: I2S (`cfg_fmt`=0) sends the MSB in slot 1 of its half. When the word fills the half, its LSB moves into slot 0 of the next half.
- R5: Right-justified (`cfg_fmt`=2) places the LSB in the last slot of its half. The MSB sits in slot (half length − word length).
- R6: `cfg_wlen` selects the word length: 0 gives 16 bits, 1 gives 20 bits, 2 and 3 give 24 bits. The word is the top bits of the 24-bit input.
- R7: Slots that carry no word bit drive `sdata_out` low.
- R8: The left sample is copied in when slot 0 of the left half begins, and the right sample when slot 0 of the right half begins. An input change at any other time does not affect the word being sent.
- R9: With `cfg_master`=0 the block follows `bclk_in` and `lrclk_in`, with each level of `lrclk_in` meaning the same channel as in R2. A frame-clock level change seen at a bit-clock fall starts slot 0 of the new half. Right-justified placement uses the length of the half-frame just before. `sdata_out` changes on the third clock edge after the fall of `bclk_in`, so each level of `bclk_in` must last at least 4 clock cycles.
- R10: In slave mode `bclk_out` and `lrclk_out` stay low.
- R11: While `rst_n` is low, `sdata_out`, `bclk_out` and `lrclk_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = generate the link clocks, 0 = follow external link clocks |
| cfg_ratio | input | 3 | Master-clock to sample-rate ratio code (see R1) |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 left-justified |
| cfg_wlen | input | 2 | Word length code (see R6) |
| smp_left | input | SAMPLE_W | Left sample, MSB-aligned |
| smp_right | input | SAMPLE_W | Right sample, MSB-aligned |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| lrclk_out | output | 1 | Generated frame clock (master mode) |
| sdata_out | output | 1 | Serial sample data |

## Verification
In master mode every output is a register loaded from next-state counter values, so the result for the n-th clock edge after reset release can be seen on that same edge. The bench counts edges from release, works out the bit period, the frame slot and the expected data from integer arithmetic, and compares all three outputs at the falling clock edge after every rising edge. In slave mode the data is due three edges after the bench lowers `bclk_in`. The bench holds each bit-clock level for eight cycles and samples data on the seventh cycle after each fall, after the update and before the rise. It skips the first frame, while the block is still measuring the half-frame length.

// File: rtl/aso_pkg.sv
package aso_pkg;

  localparam logic [1:0] FMT_I2S   = 2'd0;
  localparam logic [1:0] FMT_LEFT  = 2'd1;
  localparam logic [1:0] FMT_RIGHT = 2'd2;

  typedef struct packed {
    logic       valid;
    logic       ch;      // 0 = left word, 1 = right word
    logic [5:0] idx;     // bit position counted from the MSB
  } pick_t;

  // word length in bits for a length code
  function automatic int word_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  // master clock cycles per bit period
  function automatic int unsigned clk_per_bit(input logic [2:0] r);
    case (r)
      3'd0:    return 2;
      3'd1:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 16;
      default: return 4;
    endcase
  endfunction

  // bit periods per half-frame
  function automatic int unsigned half_bits(input logic [2:0] r);
    if (r == 3'd1 || r == 3'd5) return 24;
    return 32;
  endfunction

  // map a slot of a half-frame onto a word bit
  function automatic pick_t pick_bit(input logic [1:0] fmt, input int w,
                                     input int hprev, input logic half,
                                     input int slot);
    pick_t r;
    int    j;
    r.ch = half;
    j    = slot;
    case (fmt)
      FMT_I2S: begin
        if (slot == 0) begin
          r.ch = ~half;
          j    = hprev - 1;
        end else begin
          j = slot - 1;
        end
      end
      FMT_RIGHT: j = slot - hprev + w;
      default:   j = slot;
    endcase
    r.valid = (j >= 0) && (j < w);
    r.idx   = r.valid ? 6'(j) : 6'd0;
    return r;
  endfunction

endpackage

// File: rtl/aso_clk_master.sv
module aso_clk_master
  import aso_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        ratio,
  input  logic [1:0]        fmt,
  output logic              go,
  output logic              nxt_half,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [SLOT_W:0]   hlen,
  output logic              bclk_o,
  output logic              lrclk_o
);
  localparam int FR_W = SLOT_W + 1;

  int unsigned      dper;
  int unsigned      hb;
  logic             run;
  logic             first;
  logic             wrap;
  logic [DIV_W-1:0] dcnt, dcnt_n;
  logic [FR_W-1:0]  pos, pos_n;

  always_comb begin
    dper  = clk_per_bit(ratio);
    hb    = half_bits(ratio);
    first = en & ~run;
    wrap  = en & run & (dcnt == DIV_W'(dper - 1));
    go    = first | wrap;
    dcnt_n = dcnt;
    pos_n  = pos;
    if (go)      dcnt_n = '0;
    else if (en) dcnt_n = dcnt + 1'b1;
    if (first)     pos_n = '0;
    else if (wrap) pos_n = (pos == FR_W'(2 * hb - 1)) ? '0 : pos + 1'b1;
    nxt_half = (pos_n >= FR_W'(hb));
    nxt_slot = SLOT_W'(nxt_half ? pos_n - FR_W'(hb) : pos_n);
    hlen     = FR_W'(hb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      dcnt    <= '0;
      pos     <= '0;
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
    end else begin
      run    <= en;
      dcnt   <= dcnt_n;
      pos    <= pos_n;
      bclk_o <= en & (dcnt_n >= DIV_W'(dper / 2));
      if (!en)     lrclk_o <= 1'b0;
      else if (go) lrclk_o <= (fmt == FMT_I2S) ? nxt_half : ~nxt_half;
    end
  end

  // R1: frame position stays inside the frame
  assert_slot_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pos < FR_W'(2 * hb));
  // R1: a new bit period starts with the bit clock low
  assert_bclk_low_at_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !bclk_o);
  // R2: frame clock moves only with a bit clock fall
  assert_lr_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(run) && !$stable(lrclk_o)) |-> $fell(bclk_o));

endmodule

// File: rtl/aso_clk_slave.sv
module aso_clk_slave
  import aso_pkg::*;
#(
  parameter int SLOT_W   = 6,
  parameter int SYNC_N   = 2,
  parameter int DEF_HALF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        fmt,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  output logic              go,
  output logic              nxt_half,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [SLOT_W:0]   nxt_hprev
);
  localparam int LEN_W = SLOT_W + 1;

  logic [SYNC_N:0]   bsh;
  logic [SYNC_N-1:0] lsh;
  logic              fall;
  logic              lvl;
  logic              change;
  logic              cur_half;
  logic [SLOT_W-1:0] slot;
  logic [LEN_W-1:0]  hprev;

  always_comb begin
    fall     = en & bsh[SYNC_N] & ~bsh[SYNC_N-1];
    lvl      = lsh[SYNC_N-1];
    nxt_half = (fmt == FMT_I2S) ? lvl : ~lvl;
    change   = (nxt_half != cur_half);
    go       = fall;
    if (change)          nxt_slot = '0;
    else if (&slot)      nxt_slot = slot;
    else                 nxt_slot = slot + 1'b1;
    nxt_hprev = change ? ({1'b0, slot} + 1'b1) : hprev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsh      <= '0;
      lsh      <= '0;
      cur_half <= 1'b1;
      slot     <= '0;
      hprev    <= LEN_W'(DEF_HALF);
    end else begin
      bsh <= {bsh[SYNC_N-1:0], bclk_i};
      lsh <= {lsh[SYNC_N-2:0], lrclk_i};
      if (fall) begin
        cur_half <= nxt_half;
        slot     <= nxt_slot;
        hprev    <= nxt_hprev;
      end
    end
  end

  // R9: slot tracking advances only on a detected bit clock fall
  assert_slot_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot) |-> $past(fall));
  // R9: a measured half-frame is never empty
  assert_hprev_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hprev != '0);

endmodule

// File: rtl/aso_shift_out.sv
module aso_shift_out
  import aso_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                nxt_half,
  input  logic [SLOT_W-1:0]   nxt_slot,
  input  logic [SLOT_W:0]     hprev,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wsel,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  output logic                sdata
);
  localparam int IW = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] hold_l, hold_r, word;
  logic                latch_l, latch_r;
  logic                bit_nxt;
  int                  wl;
  pick_t               pk;
  logic [IW-1:0]       sel;

  always_comb begin
    latch_l = go & ~nxt_half & (nxt_slot == '0);
    latch_r = go &  nxt_half & (nxt_slot == '0);
    wl      = (word_len(wsel) > SAMPLE_W) ? SAMPLE_W : word_len(wsel);
    pk      = pick_bit(fmt, wl, int'(hprev), nxt_half, int'(nxt_slot));
    if (pk.ch) word = latch_r ? smp_r : hold_r;
    else       word = latch_l ? smp_l : hold_l;
    sel     = IW'(SAMPLE_W - 1 - int'(pk.idx));
    bit_nxt = pk.valid & word[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      sdata  <= 1'b0;
    end else begin
      if (latch_l) hold_l <= smp_l;
      if (latch_r) hold_r <= smp_r;
      if (go)      sdata  <= bit_nxt;
    end
  end

  // R7: empty slots send zero
  assert_unused_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !pk.valid) |=> !sdata);
  // R8: held words change only at their half-frame start
  assert_hold_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_l) |-> $past(latch_l));
  assert_hold_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_r) |-> $past(latch_r));
  // R3: data moves only at a slot start
  assert_data_on_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(go));

endmodule

// File: rtl/aso_port.sv
module aso_port
  import aso_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 6,
  parameter int DIV_W    = 5,
  parameter int SYNC_N   = 2,
  parameter int DEF_HALF = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic [2:0]          cfg_ratio,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_wlen,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  output logic                bclk_out,
  output logic                lrclk_out,
  output logic                sdata_out
);
  localparam int LEN_W = SLOT_W + 1;

  logic              m_go, s_go, go;
  logic              m_half, s_half, half;
  logic [SLOT_W-1:0] m_slot, s_slot, slot;
  logic [LEN_W-1:0]  m_hlen, s_hprev, hprev;

  aso_clk_master #(.SLOT_W(SLOT_W), .DIV_W(DIV_W)) u_mst (
    .clk(clk), .rst_n(rst_n), .en(cfg_master), .ratio(cfg_ratio), .fmt(cfg_fmt),
    .go(m_go), .nxt_half(m_half), .nxt_slot(m_slot), .hlen(m_hlen),
    .bclk_o(bclk_out), .lrclk_o(lrclk_out)
  );

  aso_clk_slave #(.SLOT_W(SLOT_W), .SYNC_N(SYNC_N), .DEF_HALF(DEF_HALF)) u_slv (
    .clk(clk), .rst_n(rst_n), .en(~cfg_master), .fmt(cfg_fmt),
    .bclk_i(bclk_in), .lrclk_i(lrclk_in),
    .go(s_go), .nxt_half(s_half), .nxt_slot(s_slot), .nxt_hprev(s_hprev)
  );

  always_comb begin
    go    = cfg_master ? m_go   : s_go;
    half  = cfg_master ? m_half : s_half;
    slot  = cfg_master ? m_slot : s_slot;
    hprev = cfg_master ? m_hlen : s_hprev;
  end

  aso_shift_out #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .go(go), .nxt_half(half), .nxt_slot(slot),
    .hprev(hprev), .fmt(cfg_fmt), .wsel(cfg_wlen),
    .smp_l(smp_left), .smp_r(smp_right), .sdata(sdata_out)
  );

  // R3: in master mode data changes while the bit clock is low
  assert_data_while_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !$stable(sdata_out)) |-> !bclk_out);
  // R10: link clock outputs idle in slave mode
  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!bclk_out && !lrclk_out));

endmodule

// File: tb/sim_aso_port.sv
`timescale 1ns/1ps
module sim_aso_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b1;
  logic [2:0]  cfg_ratio = 3'd2;
  logic [1:0]  cfg_fmt = 2'd0;
  logic [1:0]  cfg_wlen = 2'd2;
  logic [23:0] smp_left = '0;
  logic [23:0] smp_right = '0;
  logic        bclk_in = 1'b1;
  logic        lrclk_in = 1'b0;
  logic        bclk_out, lrclk_out, sdata_out;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  aso_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_ratio(cfg_ratio),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .smp_left(smp_left), .smp_right(smp_right),
    .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .bclk_out(bclk_out), .lrclk_out(lrclk_out), .sdata_out(sdata_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bits_of(input int code);
    return (code == 0) ? 16 : (code == 1) ? 20 : 24;
  endfunction

  function automatic int ratio_of(input int r);
    case (r)
      0: return 128; 1: return 192; 2: return 256;
      3: return 384; 4: return 512; default: return 768;
    endcase
  endfunction

  function automatic int frame_len(input int r);
    return (r == 1 || r == 5) ? 48 : 64;
  endfunction

  // each channel's word starts at a fixed frame position; walk back from p
  function automatic logic expect_bit(input int fmt, input int w, input int h,
                                      input int p, input logic [23:0] wl,
                                      input logic [23:0] wr);
    for (int c = 0; c < 2; c++) begin
      int st, k;
      st = c * h + ((fmt == 0) ? 1 : (fmt == 2) ? (h - w) : 0);
      k  = (p - st + 2 * h) % (2 * h);
      if (k < w) return (c == 0) ? wl[23 - k] : wr[23 - k];
    end
    return 1'b0;
  endfunction

  function automatic string data_tag(input int fmt);
    if (fmt == 0) return "R4 R6 R7 R8 i2s data";
    if (fmt == 2) return "R5 R6 R7 R8 rj data";
    return "R3 R6 R7 R8 lj data";
  endfunction

  task automatic do_reset(input bit mst, input int fmt, input int ws, input int r);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_master = mst;
    cfg_fmt = 2'(fmt);
    cfg_wlen = 2'(ws);
    cfg_ratio = 3'(r);
    bclk_in = 1'b1;
    lrclk_in = (fmt == 0) ? 1'b1 : 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset sdata", sdata_out, 1'b0);
    chk("R11 reset bclk", bclk_out, 1'b0);
    chk("R11 reset lrclk", lrclk_out, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic run_master(input int fmt, input int ws, input int r, input int frames);
    int fb, d, h, w;
    logic [23:0] hl, hr;
    fb = frame_len(r);
    d  = ratio_of(r) / fb;
    h  = fb / 2;
    w  = bits_of(ws);
    hl = '0;
    hr = '0;
    do_reset(1'b1, fmt, ws, r);
    for (int n = 0; n < frames * ratio_of(r); n++) begin
      int p;
      @(posedge clk);
      p = (n / d) % fb;
      if (n % d == 0 && p == 0) hl = smp_left;
      if (n % d == 0 && p == h) hr = smp_right;
      @(negedge clk);
      chk("R1 bclk", bclk_out, ((n % d) >= d / 2));
      chk("R2 lrclk", lrclk_out, (fmt == 0) ? (p >= h) : (p < h));
      chk(data_tag(fmt), sdata_out, expect_bit(fmt, w, h, p, hl, hr));
      if ($urandom_range(0, 29) == 0) begin
        smp_left  = 24'($urandom);
        smp_right = 24'($urandom);
      end
    end
  endtask

  task automatic run_slave(input int fmt, input int ws, input int h, input int frames);
    int w;
    logic [23:0] hl, hr;
    w  = bits_of(ws);
    hl = '0;
    hr = '0;
    do_reset(1'b0, fmt, ws, 2);
    for (int g = 0; g < frames * 2 * h; g++) begin
      int p;
      p = g % (2 * h);
      @(negedge clk);
      bclk_in  = 1'b0;
      lrclk_in = (fmt == 0) ? (p >= h) : (p < h);
      if (p == 0) hl = smp_left;
      if (p == h) hr = smp_right;
      repeat (3) @(negedge clk);
      if (p == h / 2 || p == h + h / 2) begin
        smp_left  = 24'($urandom);
        smp_right = 24'($urandom);
      end
      repeat (4) @(negedge clk);
      if (g >= 2 * h) begin
        chk({"R9 slave ", data_tag(fmt)}, sdata_out, expect_bit(fmt, w, h, p, hl, hr));
        chk("R10 slave bclk_out", bclk_out, 1'b0);
        chk("R10 slave lrclk_out", lrclk_out, 1'b0);
      end
      @(negedge clk);
      bclk_in = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  initial begin
    for (int r = 0; r < 6; r++)
      for (int f = 0; f < 3; f++)
        for (int ws = 0; ws < 3; ws++)
          run_master(f, ws, r, 2);
    run_master(1, 3, 2, 1);      // R6 code 3 also means 24 bits
    run_master(3, 1, 0, 1);      // R3 format code 3 acts as left-justified
    for (int f = 0; f < 3; f++)
      for (int ws = 0; ws < 3; ws++)
        run_slave(f, ws, 32, 3);
    for (int f = 0; f < 3; f++)
      run_slave(f, 2, 24, 3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule